// File: doc/BRIEF.md
# Indexed Color Palette Loader

This block holds a 256-entry color lookup table and loads it through a small register-style write port in the manner of a classic RAMDAC. The host first writes an entry number into the index register. It then sends color bytes to the color-map register. The block itself decides whether each byte is the red, green or blue part of the current entry. Once an entry's blue byte is stored, the block moves to the next entry.

A color-map write can carry one byte or a whole 32-bit word. A word is split into four component bytes, taken from the most significant byte down. An entry's three bytes may therefore be split across two words.

A separate lookup port turns an 8-bit pixel index into a packed 24-bit RGB value, with one cycle of latency. Every color-map write also produces a one-cycle refresh pulse. A display engine downstream uses this pulse to redraw the whole image.

Top module: `palette_loader`

## Requirements
- R1: While reset is held and after it is released, every entry reads back as 0x000000 on the lookup port, the next color byte goes to red, and `refresh` is low.
- R2: A write to offset 0x0 loads `bus_wdata[7:0]` as the current entry index and returns the component step to red, even in the middle of an entry.
- R3: A write to offset 0x4 whose `bus_size` is not 4 delivers one byte, `bus_wdata[7:0]`. Successive bytes are stored into red, then green, then blue of the current entry, and the step then returns to red.
- R4: Storing a blue byte advances the entry index by one, modulo 256, so index 255 is followed by index 0.
- R5: A write to offset 0x4 with `bus_size` equal to 4 delivers four bytes in one cycle, in the order `bus_wdata[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`. The bytes continue the red/green/blue sequence and the index advance exactly as four single-byte writes would.
- R6: `pix_rgb` shows the entry selected by `pix_idx` one cycle later, with red in bits 23:16, green in 15:8 and blue in 7:0. If a color write to the same entry happens in that same cycle, `pix_rgb` shows the old value.
- R7: `refresh` is high for exactly the one cycle that follows each color-map write. It stays low after index writes and after idle cycles.
- R8: `bus_rdata` is always zero. Writes to any offset other than 0x0 and 0x4 change neither the table, the index nor the component step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 5 | Register offset |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Pixel index to look up |
| pix_rgb | output | 24 | Packed color of the looked-up entry |
| refresh | output | 1 | Full-image refresh request pulse |

## Verification
The assertions assume the following about the inputs:
- The write inputs are free of unknown values at every rising edge.
- `bus_size` and `bus_wdata` only matter on cycles where `bus_wr` is high.
- The step counter never takes the unused code.

The bench keeps to these assumptions. It drives every input on the falling edge from a known value and returns `bus_wr` to zero between accesses. It uses size 4 for word writes and sizes 1 and 2 for byte writes. Reads are observed only through the lookup port, one cycle after the index is applied.

// File: rtl/palette_loader.sv
module palette_loader #(
  parameter int IDX_W = 8,
  parameter int CW    = 8,
  parameter int AW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [2:0]        bus_size,
  input  logic [4*CW-1:0]   bus_wdata,
  output logic [4*CW-1:0]   bus_rdata,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [3*CW-1:0]   pix_rgb,
  output logic              refresh
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int LANES   = 4;
  localparam int DW      = LANES * CW;
  localparam logic [AW-1:0] OFS_INDEX = AW'(0);
  localparam logic [AW-1:0] OFS_CMAP  = AW'(4);

  logic [CW-1:0]    red_q [ENTRIES];
  logic [CW-1:0]    grn_q [ENTRIES];
  logic [CW-1:0]    blu_q [ENTRIES];
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       phase_q;

  logic             idx_wr, cmap_wr, wide;
  logic [2:0]       lane_sum  [LANES];
  logic [1:0]       lane_ph   [LANES];
  logic [IDX_W-1:0] lane_idx  [LANES];
  logic [CW-1:0]    lane_dat  [LANES];
  logic             lane_en   [LANES];
  logic [2:0]       adv;

  assign idx_wr    = bus_wr && (bus_addr == OFS_INDEX);
  assign cmap_wr   = bus_wr && (bus_addr == OFS_CMAP);
  assign wide      = (bus_size == 3'd4);
  assign bus_rdata = '0;
  assign adv       = {1'b0, phase_q} + (wide ? 3'd4 : 3'd1);

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      lane_sum[k] = {1'b0, phase_q} + 3'(k);
      if (lane_sum[k] >= 3'd3) begin
        lane_ph[k]  = 2'(lane_sum[k] - 3'd3);
        lane_idx[k] = idx_q + IDX_W'(1);
      end else begin
        lane_ph[k]  = lane_sum[k][1:0];
        lane_idx[k] = idx_q;
      end
      lane_dat[k] = wide ? bus_wdata[DW-1-k*CW -: CW] : bus_wdata[CW-1:0];
      lane_en[k]  = cmap_wr && ((k == 0) || wide);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      phase_q <= 2'd0;
    end else if (idx_wr) begin
      idx_q   <= bus_wdata[IDX_W-1:0];
      phase_q <= 2'd0;
    end else if (cmap_wr) begin
      if (adv >= 3'd6) begin
        idx_q   <= idx_q + IDX_W'(2);
        phase_q <= 2'd0;
      end else if (adv >= 3'd3) begin
        idx_q   <= idx_q + IDX_W'(1);
        phase_q <= 2'(adv - 3'd3);
      end else begin
        phase_q <= adv[1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        red_q[e] <= '0;
        grn_q[e] <= '0;
        blu_q[e] <= '0;
      end
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (lane_en[k]) begin
          case (lane_ph[k])
            2'd0:    red_q[lane_idx[k]] <= lane_dat[k];
            2'd1:    grn_q[lane_idx[k]] <= lane_dat[k];
            default: blu_q[lane_idx[k]] <= lane_dat[k];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_rgb <= '0;
      refresh <= 1'b0;
    end else begin
      pix_rgb <= {red_q[pix_idx], grn_q[pix_idx], blu_q[pix_idx]};
      refresh <= cmap_wr;
    end
  end
endmodule

module palette_loader_chk #(
  parameter int IDX_W = 8,
  parameter int CW    = 8,
  parameter int AW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [2:0]       bus_size,
  input logic [4*CW-1:0]  bus_wdata,
  input logic             refresh,
  input logic [IDX_W-1:0] idx,
  input logic [1:0]       phase
);
  logic iw, cw, other;
  assign iw    = bus_wr && (bus_addr == AW'(0));
  assign cw    = bus_wr && (bus_addr == AW'(4));
  assign other = !iw && !cw;

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3); // R3
  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    iw |=> (idx == $past(bus_wdata[IDX_W-1:0])) && (phase == 2'd0)); // R2
  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && bus_size != 3'd4) |=>
      (phase == (($past(phase) == 2'd2) ? 2'd0 : $past(phase) + 2'd1))); // R3
  AST_BLUE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && bus_size != 3'd4 && phase == 2'd2) |=> (idx == $past(idx) + IDX_W'(1))); // R4
  AST_RED_GREEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && bus_size != 3'd4 && phase != 2'd2) |=> $stable(idx)); // R4
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && bus_size == 3'd4) |=>
      (idx == $past(idx) + (($past(phase) == 2'd2) ? IDX_W'(2) : IDX_W'(1))) &&
      (phase == (($past(phase) == 2'd2) ? 2'd0 : $past(phase) + 2'd1))); // R5
  AST_REFRESH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cw |=> refresh); // R7
  AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cw |=> !refresh); // R7
  AST_OTHER_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    other |=> $stable(idx) && $stable(phase)); // R8
endmodule

bind palette_loader palette_loader_chk #(.IDX_W(IDX_W), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_size(bus_size), .bus_wdata(bus_wdata), .refresh(refresh),
  .idx(idx_q), .phase(phase_q)
);

// File: tb/palette_loader_bench.sv
module palette_loader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [2:0]  bus_size = 3'd1;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;
  logic        refresh;

  int checks = 0;
  int failures = 0;

  logic [7:0] mr [256];
  logic [7:0] mg [256];
  logic [7:0] mb [256];
  logic [7:0] m_idx = '0;
  int         m_ph = 0;

  always #2 clk = ~clk;

  palette_loader u_palette_loader (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb), .refresh(refresh)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_byte(input logic [7:0] b);
    case (m_ph)
      0: mr[m_idx] = b;
      1: mg[m_idx] = b;
      default: mb[m_idx] = b;
    endcase
    if (m_ph == 2) begin
      m_ph = 0;
      m_idx = m_idx + 8'd1;
    end else m_ph++;
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [2:0] sz,
                           input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 5'd0) begin
      m_idx = d[7:0]; m_ph = 0;
    end else if (a == 5'd4) begin
      if (sz == 3'd4) begin
        for (int k = 3; k >= 0; k--) model_byte(d[8*k +: 8]);
      end else model_byte(d[7:0]);
    end
  endtask

  task automatic check_entry(input logic [7:0] e, input string req);
    @(negedge clk);
    pix_idx = e;
    @(negedge clk);
    check(pix_rgb == {mr[e], mg[e], mb[e]}, req, {8'h0, pix_rgb},
          {8'h0, mr[e], mg[e], mb[e]});
  endtask

  task automatic t_reset;
    check(refresh == 1'b0, "R1 refresh", {31'd0, refresh}, 32'd0);
    check(bus_rdata == 32'd0, "R8 rdata", bus_rdata, 32'd0);
    check_entry(8'd0, "R1 entry0");
    check_entry(8'd128, "R1 entry128");
    check_entry(8'd255, "R1 entry255");
  endtask

  task automatic t_single_bytes;
    bus_write(5'd0, 3'd1, 32'd10);
    bus_write(5'd4, 3'd1, 32'h11);
    bus_write(5'd4, 3'd1, 32'h22);
    bus_write(5'd4, 3'd1, 32'h33);
    bus_write(5'd4, 3'd1, 32'h44);
    check_entry(8'd10, "R3 triplet");
    check(pix_rgb == 24'h112233, "R6 packing", {8'h0, pix_rgb}, 32'h112233);
    check_entry(8'd11, "R4 next entry red");
    bus_write(5'd4, 3'd2, 32'h1234_5678);
    check_entry(8'd11, "R3 size2 low byte");
    check(pix_rgb == 24'h447800, "R3 size2 green", {8'h0, pix_rgb}, 32'h447800);
  endtask

  task automatic t_wrap;
    bus_write(5'd0, 3'd1, 32'd255);
    bus_write(5'd4, 3'd1, 32'hA1);
    bus_write(5'd4, 3'd1, 32'hA2);
    bus_write(5'd4, 3'd1, 32'hA3);
    bus_write(5'd4, 3'd1, 32'hB1);
    check_entry(8'd255, "R4 entry255");
    check_entry(8'd0, "R4 wrap to 0");
    check(pix_rgb == 24'hB10000, "R4 wrap value", {8'h0, pix_rgb}, 32'hB10000);
  endtask

  task automatic t_word;
    bus_write(5'd0, 3'd4, 32'd20);
    bus_write(5'd4, 3'd4, 32'hAABB_CCDD);
    bus_write(5'd4, 3'd4, 32'h1122_3344);
    bus_write(5'd4, 3'd4, 32'h5566_7788);
    check_entry(8'd20, "R5 word entry20");
    check(pix_rgb == 24'hAABBCC, "R5 msb first", {8'h0, pix_rgb}, 32'hAABBCC);
    check_entry(8'd21, "R5 span entry21");
    check(pix_rgb == 24'hDD1122, "R5 span value", {8'h0, pix_rgb}, 32'hDD1122);
    check_entry(8'd22, "R5 entry22");
    check_entry(8'd23, "R5 entry23");
    bus_write(5'd4, 3'd1, 32'h99);
    check_entry(8'd24, "R5 byte after words");
  endtask

  task automatic t_reindex;
    bus_write(5'd0, 3'd1, 32'd30);
    bus_write(5'd4, 3'd1, 32'h01);
    bus_write(5'd4, 3'd1, 32'h02);
    bus_write(5'd0, 3'd1, 32'd40);
    bus_write(5'd4, 3'd1, 32'h05);
    check_entry(8'd30, "R2 partial entry kept");
    check_entry(8'd40, "R2 restart at red");
    check(pix_rgb == 24'h050000, "R2 red value", {8'h0, pix_rgb}, 32'h050000);
  endtask

  task automatic t_refresh;
    bus_write(5'd4, 3'd1, 32'h07);
    check(refresh == 1'b1, "R7 pulse high", {31'd0, refresh}, 32'd1);
    @(negedge clk);
    check(refresh == 1'b0, "R7 pulse one cycle", {31'd0, refresh}, 32'd0);
    bus_write(5'd0, 3'd1, 32'd60);
    check(refresh == 1'b0, "R7 no pulse on index", {31'd0, refresh}, 32'd0);
    bus_write(5'd4, 3'd4, 32'h0102_0304);
    check(refresh == 1'b1, "R7 pulse on word", {31'd0, refresh}, 32'd1);
  endtask

  task automatic t_collide;
    logic [23:0] old_v;
    bus_write(5'd0, 3'd1, 32'd50);
    old_v = {mr[50], mg[50], mb[50]};
    @(negedge clk);
    pix_idx = 8'd50;
    bus_wr = 1'b1; bus_addr = 5'd4; bus_size = 3'd1; bus_wdata = 32'hEE;
    @(negedge clk);
    bus_wr = 1'b0;
    model_byte(8'hEE);
    check(pix_rgb == old_v, "R6 old value on collision", {8'h0, pix_rgb}, {8'h0, old_v});
    @(negedge clk);
    check(pix_rgb == 24'hEE0000, "R6 new value next cycle", {8'h0, pix_rgb}, 32'hEE0000);
  endtask

  task automatic t_other_addr;
    bus_write(5'd0, 3'd1, 32'd70);
    bus_write(5'd4, 3'd1, 32'h31);
    bus_write(5'd16, 3'd4, 32'hFFFF_FFFF);
    bus_write(5'd8, 3'd1, 32'd90);
    check(refresh == 1'b0, "R8 no refresh", {31'd0, refresh}, 32'd0);
    bus_write(5'd4, 3'd1, 32'h32);
    check_entry(8'd70, "R8 step unchanged");
    check(pix_rgb == 24'h313200, "R8 value", {8'h0, pix_rgb}, 32'h313200);
    check_entry(8'd90, "R8 entry90 untouched");
    check(bus_rdata == 32'd0, "R8 rdata zero", bus_rdata, 32'd0);
  endtask

  initial begin
    for (int e = 0; e < 256; e++) begin
      mr[e] = '0; mg[e] = '0; mb[e] = '0;
    end
    repeat (3) @(negedge clk);
    check(pix_rgb == 24'd0, "R1 in reset", {8'h0, pix_rgb}, 32'd0);
    rst_n = 1'b1;
    t_reset();
    t_single_bytes();
    t_wrap();
    t_word();
    t_reindex();
    t_refresh();
    t_collide();
    t_other_addr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule